// File: doc/BRIEF.md
# Power-Status LED Pattern Controller

This block sits in a board management controller and turns a handful of supply and control status signals into the patterns on two indicator LEDs, one green and one red. Each status input is first passed through a two-flop synchronizer. A fixed-priority decoder then picks one status condition. A shared divider and phase counter generate every blink waveform, so all patterns stay aligned to a single timebase. The patterns are: both LEDs steady on, a slow 1/8-duty blink, steady red, and 50 % blinks at 4 Hz or 1 Hz.

Once the supplies are good and the processor has left reset, the green LED can follow a user signal instead of the controller's own pattern. If the controller ever reports that it could not power the processor, that handover is blocked until the block itself is reset. Both LED outputs are registered. Their drive polarity is set by a parameter. Every pin is a plain level signal; nothing here streams data, so there is no handshake.

Top module: `pled_top`

## Requirements
- R1: While `rst_n` is low, both LEDs are driven to their unlit level, and the blink timebase restarts from phase 0.
- R2: When the synchronized `resin_n_in` is low or `bank_ok_in` is low, both LEDs are lit steadily. This condition overrides every other condition.
- R3: Otherwise, when `en_in` is low, green is lit steadily. Red is lit only while the 5-bit phase is 0 to 3, giving 4 lit ticks out of every 32 (250 ms in 2 s).
- R4: Otherwise, when `vin_ok_in` or `vout_ok_in` is low, green is unlit and red is lit steadily.
- R5: Otherwise, with `boot_sd_in` = 0 (serial flash boot), red is lit when phase bit 1 is 1. This is a 4 Hz, 50 % blink.
- R6: Otherwise, with `boot_sd_in` = 1 (card boot), red is lit when phase bit 3 is 1. This is a 1 Hz, 50 % blink.
- R7: In the conditions of R5 and R6, green follows the synchronized `user_led_in` when `por_rel_in` is high and no power failure has been latched. In every other case in those conditions, green is unlit.
- R8: A high `pwr_fail_in`, once synchronized, is latched until `rst_n`. From the following cycle on, green never follows the user signal.
- R9: Each input passes through two flip-flops and the LED register. A change sampled at clock edge k appears on the LEDs after edge k+2.
- R10: The phase counter advances by one, modulo 32, once every `TICK_DIV` clocks. That is 1/16 s at the default setting. The first advance happens `TICK_DIV`+1 edges after reset is released.
- R11: With `ACTIVE_HIGH` = 1, a lit LED drives 1. With `ACTIVE_HIGH` = 0, every output level is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| en_in | input | 1 | Module enable; low means powerdown |
| resin_n_in | input | 1 | External reset request, active low |
| bank_ok_in | input | 1 | I/O bank supply present |
| vin_ok_in | input | 1 | Main input supply and converters good |
| vout_ok_in | input | 1 | 3.3 V output rail good |
| boot_sd_in | input | 1 | Boot select: 0 serial flash, 1 card |
| por_rel_in | input | 1 | Processor power-on reset released |
| pwr_fail_in | input | 1 | Controller could not enable processor power |
| user_led_in | input | 1 | User value for the green LED after handover |
| led_green | output | 1 | Green LED drive |
| led_red | output | 1 | Red LED drive |

## Verification
The bench drives overlapping conditions to test the priority order. In one case the bank supply fails while the enable pin is also low and power is otherwise good. A decoder with the wrong order would show a blink instead of the steady pair. The bench checks that a one-cycle `pwr_fail_in` pulse permanently blocks the green handover, and that only a block reset clears it. A non-sticky latch would let the user signal back through. It also toggles `user_led_in` before `por_rel_in` rises, to catch a design that hands over too early. Every cycle is compared against a model that counts edges since reset. Phase off by one tick, or a missing synchronizer stage, shows up as a mismatch at a blink edge or at a status change.

// File: rtl/pled_pkg.sv
package pled_pkg;

  localparam int PHASE_W = 5;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_PWRDN    = 3'd1,
    ST_FAULT    = 3'd2,
    ST_BOOT_SPI = 3'd3,
    ST_BOOT_SD  = 3'd4
  } pled_state_e;

  typedef struct packed {
    logic resin_n;
    logic bank_ok;
    logic en;
    logic vin_ok;
    logic vout_ok;
    logic boot_sd;
    logic por_rel;
    logic pwr_fail;
    logic user_led;
  } pled_in_t;

  localparam int IN_W = $bits(pled_in_t);

endpackage

// File: rtl/pled_sync.sv
module pled_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pled_tick.sv
module pled_tick #(
  parameter int TICK_DIV = 3_125_000,
  parameter int PHASE_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               tick,
  output logic [PHASE_W-1:0] phase
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic               tick_q;
  logic [PHASE_W-1:0] phase_q;
  logic               wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + CNT_W'(1);
      tick_q <= wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick_q) phase_q <= phase_q + PHASE_W'(1);
  end

  assign tick  = tick_q;
  assign phase = phase_q;

endmodule

// File: rtl/pled_decode.sv
module pled_decode
  import pled_pkg::*;
(
  input  pled_in_t    st,
  output pled_state_e state
);

  always_comb begin
    if (!st.resin_n || !st.bank_ok)     state = ST_RESET;
    else if (!st.en)                    state = ST_PWRDN;
    else if (!(st.vin_ok && st.vout_ok)) state = ST_FAULT;
    else if (st.boot_sd)                state = ST_BOOT_SD;
    else                                state = ST_BOOT_SPI;
  end

endmodule

// File: rtl/pled_pattern.sv
module pled_pattern
  import pled_pkg::*;
#(
  parameter int PHASE_W = 5
) (
  input  pled_state_e        state,
  input  logic [PHASE_W-1:0] phase,
  input  logic               handover,
  input  logic               user_led,
  output logic               lit_green,
  output logic               lit_red
);

  logic slow_on, fast_on, mid_on;

  assign slow_on = (phase[PHASE_W-1:PHASE_W-3] == 3'd0);
  assign fast_on = phase[1];
  assign mid_on  = phase[3];

  always_comb begin
    lit_green = 1'b0;
    lit_red   = 1'b0;
    unique case (state)
      ST_RESET: begin
        lit_green = 1'b1;
        lit_red   = 1'b1;
      end
      ST_PWRDN: begin
        lit_green = 1'b1;
        lit_red   = slow_on;
      end
      ST_FAULT: begin
        lit_green = 1'b0;
        lit_red   = 1'b1;
      end
      ST_BOOT_SPI: begin
        lit_green = handover & user_led;
        lit_red   = fast_on;
      end
      ST_BOOT_SD: begin
        lit_green = handover & user_led;
        lit_red   = mid_on;
      end
      default: begin
        lit_green = 1'b0;
        lit_red   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pled_top.sv
module pled_top
  import pled_pkg::*;
#(
  parameter int TICK_DIV    = 3_125_000,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic resin_n_in,
  input  logic bank_ok_in,
  input  logic vin_ok_in,
  input  logic vout_ok_in,
  input  logic boot_sd_in,
  input  logic por_rel_in,
  input  logic pwr_fail_in,
  input  logic user_led_in,
  output logic led_green,
  output logic led_red
);

  pled_in_t           raw, syn;
  logic [IN_W-1:0]    syn_bits;
  logic               tick;
  logic [PHASE_W-1:0] phase;
  pled_state_e        state;
  logic               fail_q;
  logic               handover;
  logic               lit_g, lit_r;
  logic               drv_g, drv_r;

  always_comb begin
    raw.resin_n  = resin_n_in;
    raw.bank_ok  = bank_ok_in;
    raw.en       = en_in;
    raw.vin_ok   = vin_ok_in;
    raw.vout_ok  = vout_ok_in;
    raw.boot_sd  = boot_sd_in;
    raw.por_rel  = por_rel_in;
    raw.pwr_fail = pwr_fail_in;
    raw.user_led = user_led_in;
  end

  pled_sync #(.W(IN_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn_bits)
  );
  assign syn = pled_in_t'(syn_bits);

  pled_tick #(.TICK_DIV(TICK_DIV), .PHASE_W(PHASE_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .phase (phase)
  );

  pled_decode u_dec (
    .st    (syn),
    .state (state)
  );

  // Sticky record that processor power could not be enabled.
  always_ff @(posedge clk) begin
    if (!rst_n)            fail_q <= 1'b0;
    else if (syn.pwr_fail) fail_q <= 1'b1;
  end

  assign handover = syn.por_rel & ~fail_q;

  pled_pattern #(.PHASE_W(PHASE_W)) u_pat (
    .state     (state),
    .phase     (phase),
    .handover  (handover),
    .user_led  (syn.user_led),
    .lit_green (lit_g),
    .lit_red   (lit_r)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pos
      assign drv_g = lit_g;
      assign drv_r = lit_r;
    end else begin : g_neg
      assign drv_g = ~lit_g;
      assign drv_r = ~lit_r;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_green <= ~ACTIVE_HIGH;
      led_red   <= ~ACTIVE_HIGH;
    end else begin
      led_green <= drv_g;
      led_red   <= drv_r;
    end
  end

endmodule

// File: rtl/pled_chk.sv
module pled_chk #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       resin_s,
  input logic       bank_s,
  input logic       en_s,
  input logic       vin_s,
  input logic       vout_s,
  input logic       por_s,
  input logic       fail_q,
  input logic       tick,
  input logic [4:0] phase,
  input logic       led_green,
  input logic       led_red
);

  logic g_lit, r_lit, live;
  assign g_lit = ACTIVE_HIGH ? led_green : ~led_green;
  assign r_lit = ACTIVE_HIGH ? led_red   : ~led_red;
  assign live  = resin_s & bank_s;

  p_reset_off_r1: assert property (@(posedge clk)
    !rst_n |=> (!g_lit && !r_lit));

  p_reset_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (g_lit && r_lit));

  p_pwrdn_green_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !en_s) |=> g_lit);

  p_fault_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && en_s && !(vin_s && vout_s)) |=> (!g_lit && r_lit));

  p_no_early_hand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && en_s && vin_s && vout_s && !por_s) |=> !g_lit);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> fail_q);

  p_fail_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && live && en_s && vin_s && vout_s) |=> !g_lit);

  p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  p_phase_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == $past(phase) + 5'd1));

endmodule

bind pled_top pled_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .resin_s   (syn.resin_n),
  .bank_s    (syn.bank_ok),
  .en_s      (syn.en),
  .vin_s     (syn.vin_ok),
  .vout_s    (syn.vout_ok),
  .por_s     (syn.por_rel),
  .fail_q    (fail_q),
  .tick      (tick),
  .phase     (phase),
  .led_green (led_green),
  .led_red   (led_red)
);

// File: tb/pled_top_tb.sv
module pled_top_tb;

  localparam int DIV = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic en = 0, resin_n = 0, bank_ok = 0, vin_ok = 0, vout_ok = 0;
  logic boot_sd = 0, por_rel = 0, pwr_fail = 0, user_led = 0;
  logic led_green, led_red, inv_green, inv_red;

  pled_top #(.TICK_DIV(DIV), .ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_in(en), .resin_n_in(resin_n),
    .bank_ok_in(bank_ok), .vin_ok_in(vin_ok), .vout_ok_in(vout_ok),
    .boot_sd_in(boot_sd), .por_rel_in(por_rel), .pwr_fail_in(pwr_fail),
    .user_led_in(user_led), .led_green(led_green), .led_red(led_red)
  );

  pled_top #(.TICK_DIV(DIV), .ACTIVE_HIGH(1'b0)) u_inv (
    .clk(clk), .rst_n(rst_n), .en_in(en), .resin_n_in(resin_n),
    .bank_ok_in(bank_ok), .vin_ok_in(vin_ok), .vout_ok_in(vout_ok),
    .boot_sd_in(boot_sd), .por_rel_in(por_rel), .pwr_fail_in(pwr_fail),
    .user_led_in(user_led), .led_green(inv_green), .led_red(inv_red)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // Behavioural reference: inputs seen two edges ago, phase from edge count.
  typedef bit [8:0] vec_t;
  vec_t hist[$];
  int   edges = 0;
  bit   sticky = 0;
  bit   exp_g = 0, exp_r = 0;
  string exp_tag = "R1";

  function automatic vec_t pack_in();
    return {resin_n, bank_ok, en, vin_ok, vout_ok, boot_sd, por_rel, pwr_fail, user_led};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      edges = 0; sticky = 0; hist = {};
      hist.push_back('0); hist.push_back('0);
      exp_g = 0; exp_r = 0; exp_tag = "R1";
    end else begin
      vec_t v;
      int ph;
      edges++;
      hist.push_back(pack_in());
      v = hist.pop_front();
      ph = (edges >= 2) ? ((edges - 2) / DIV) % 32 : 0;
      if (!v[8] || !v[7]) begin
        exp_g = 1; exp_r = 1; exp_tag = "R2/R9";
      end else if (!v[6]) begin
        exp_g = 1; exp_r = (ph < 4); exp_tag = "R3/R10";
      end else if (!(v[5] && v[4])) begin
        exp_g = 0; exp_r = 1; exp_tag = "R4";
      end else begin
        exp_r = v[3] ? (((ph / 8) % 2) == 1) : (((ph / 2) % 2) == 1);
        exp_tag = v[3] ? "R6/R10" : "R5/R10";
        exp_g = (v[2] && !sticky) ? v[0] : 1'b0;
        if (v[2]) exp_tag = sticky ? "R8" : "R7";
      end
      if (v[1]) sticky = 1;
    end
  end

  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      checks++;
      if (led_green !== exp_g || led_red !== exp_r) begin
        errors++;
        $display("FAIL %s cycle %0d: got g=%b r=%b expected g=%b r=%b",
                 exp_tag, cycles, led_green, led_red, exp_g, exp_r);
      end
      checks++;
      if (inv_green !== ~exp_g || inv_red !== ~exp_r) begin
        errors++;
        $display("FAIL R11 cycle %0d: inverted got g=%b r=%b expected g=%b r=%b",
                 cycles, inv_green, inv_red, ~exp_g, ~exp_r);
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input bit g, input bit r);
    checks++;
    if (led_green !== g || led_red !== r) begin
      errors++;
      $display("FAIL %s directed: got g=%b r=%b expected g=%b r=%b",
               tag, led_green, led_red, g, r);
    end
  endtask

  task automatic power_good(input bit sd);
    resin_n = 1; bank_ok = 1; en = 1; vin_ok = 1; vout_ok = 1; boot_sd = sd;
  endtask

  initial begin
    hold(6);
    expect_now("R1", 1'b0, 1'b0);
    rst_n = 1;
    hold(3);
    expect_now("R2", 1'b1, 1'b1);
    hold(20);
    // Powerdown: slow 1/8 blink over more than one 32-tick period
    resin_n = 1; bank_ok = 1; en = 0;
    hold(220);
    // Input supply fault, then output rail fault
    en = 1; vin_ok = 0; vout_ok = 1;
    hold(60);
    vin_ok = 1; vout_ok = 0;
    hold(40);
    // Flash boot with processor still in reset: user toggles, no handover
    power_good(1'b0);
    for (int i = 0; i < 40; i++) begin user_led = ~user_led; hold(3); end
    // Handover
    por_rel = 1;
    for (int i = 0; i < 40; i++) begin user_led = (i % 3 == 0); hold(2); end
    // Card boot
    boot_sd = 1;
    hold(200);
    // One-cycle enable glitch checks the latency path
    en = 0; hold(1); en = 1;
    hold(20);
    // Priority: bank supply lost while enable low
    bank_ok = 0; en = 0;
    hold(30);
    expect_now("R2", 1'b1, 1'b1);
    bank_ok = 1; resin_n = 0;
    hold(20);
    power_good(1'b0);
    hold(10);
    // Single-cycle power failure latches forever
    pwr_fail = 1; hold(1); pwr_fail = 0;
    for (int i = 0; i < 60; i++) begin user_led = ~user_led; hold(2); end
    user_led = 1;
    hold(5);
    expect_now("R8", 1'b0, led_red);
    // Block reset clears the latch
    rst_n = 0;
    hold(4);
    expect_now("R1", 1'b0, 1'b0);
    rst_n = 1;
    hold(50);
    expect_now("R7", 1'b1, led_red);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule